// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter Stage

This block is a synchronous binary up-counter built from one or more identical counting stages. Each stage is a `DIGIT_W`-bit register (4 bits by default) whose bits all update on the same rising clock edge. Every stage has four inputs that shape its behaviour: an active-low parallel load, an active-low clear, and two count enables. Count enable P is a plain gate on counting. Count enable T also gates counting, and it qualifies the stage's carry output as well. The carry output is high when the stage holds all ones and T is high. It can feed the T enable of the next stage, so several stages form one wide synchronous counter with no added gating.

The top module places `N_STAGES` stages in a chain. The carry of stage k drives the T enable of stage k+1. All stages share P, load and clear. The parallel data and count buses are the stage fields concatenated, with stage 0 in the least significant bits. The chain's carry output is the carry of the last stage. A parameter sets the clear behaviour:
- **Asynchronous clear:** the clear forces zero at once, whatever the clock is doing.
- **Synchronous clear:** the clear takes effect at the next rising edge. In this mode, an external decode of a chosen count fed back into the clear gives a modulo-N counter.

Top module: `presettable_counter_chain`

## Requirements
- R1: The count changes only on a rising clock edge, and all bits change on the same edge. A pulse on load, P or T that starts and ends between two edges leaves the count unchanged.
- R2: With clear high and load low, the count equals the parallel data input after the next rising edge. This holds for any levels of P and T.
- R3: In asynchronous-clear mode (`CLR_MODE = CLR_ASYNC`), a low clear sets the count to zero at once, without waiting for a clock edge. This holds whatever the levels of load, P and T.
- R4: In synchronous-clear mode (`CLR_MODE = CLR_SYNC`), a low clear leaves the count unchanged until the next rising edge, and after that edge the count is zero. Clear takes priority over load and over both enables.
- R5: With clear and load high and both P and T high, the count increases by one on each rising edge. It wraps from all ones to zero with no extra state.
- R6: With clear and load high and either P or T low, the count holds its value.
- R7: The carry output is 1 exactly when T is 1 and the count is all ones. It responds to T combinationally, with no clock edge needed.
- R8: With `N_STAGES` stages chained, the whole `DIGIT_W*N_STAGES`-bit count behaves as one binary counter. It increments across stage boundaries and wraps from all ones to zero. Load and clear act on every stage together.
- R9: In synchronous-clear mode, driving clear low whenever the count equals 9 gives the repeating sequence 0, 1, …, 9, 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear (asynchronous or synchronous by parameter) |
| load_n | input | 1 | Active-low synchronous parallel load |
| cen_p | input | 1 | Count enable P, shared by all stages |
| cen_t | input | 1 | Count enable T of the first stage; also qualifies carry |
| pdata | input | DIGIT_W*N_STAGES | Parallel load data, stage 0 in the low bits |
| count | output | DIGIT_W*N_STAGES | Current count |
| carry_out | output | 1 | Carry of the last stage (T chain high and count all ones) |

## Verification
A single 4-bit stage is tested in both clear modes, and both copies are driven by one table of vectors. The table follows a clear, a preset to twelve, a count through the wrap to two, and then inhibits on each enable in turn. Further rows pit load against both enables and clear against load, which shows whether the priority order is right. Loading fifteen with T low and then raising T separates the gating of carry by T from its dependence on the count. Directed tests then do three things:
- They apply a mid-cycle clear to both stages, which shows the asynchronous and synchronous variants differ.
- They pulse load between edges, which shows the count ignores changes that do not span an edge.
- They feed a decode of nine back into the synchronous clear.

A three-stage chain is then loaded next to its rollover points and compared each cycle with a wide reference count. This covers a carry through one stage and a carry through two.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

   typedef enum logic {
      CLR_ASYNC = 1'b0,
      CLR_SYNC  = 1'b1
   } clr_mode_e;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_INCR  = 2'd1,
      OP_LOAD  = 2'd2,
      OP_CLEAR = 2'd3
   } cnt_op_e;

endpackage

// File: rtl/cnt_next_state.sv
// Next-state selector of one counting stage: clear, then load, then count, then hold.
module cnt_next_state #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] din,
   input  logic         clr_req,
   input  logic         ld_req,
   input  logic         inc_req,
   output logic [W-1:0] nxt
);
   import cnt_pkg::*;

   cnt_op_e op;

   always_comb begin
      if (clr_req)      op = OP_CLEAR;
      else if (ld_req)  op = OP_LOAD;
      else if (inc_req) op = OP_INCR;
      else              op = OP_HOLD;
   end

   always_comb begin
      unique case (op)
         OP_CLEAR: nxt = '0;
         OP_LOAD:  nxt = din;
         OP_INCR:  nxt = cur + W'(1);
         default:  nxt = cur;
      endcase
   end

endmodule

// File: rtl/cnt_carry.sv
// Terminal-count decode of one stage, qualified by the T enable.
module cnt_carry #(
   parameter int unsigned W = 4
) (
   input  logic [W-1:0] cur,
   input  logic         en_t,
   output logic         rco
);
   logic full;

   assign full = &cur;
   assign rco  = en_t & full;

endmodule

// File: rtl/cnt_stage.sv
// One counting stage; CLR_MODE chooses the register style.
module cnt_stage #(
   parameter int unsigned          W        = 4,
   parameter cnt_pkg::clr_mode_e   CLR_MODE = cnt_pkg::CLR_ASYNC
) (
   input  logic         clk,
   input  logic         clr_n,
   input  logic         ld_n,
   input  logic         en_p,
   input  logic         en_t,
   input  logic [W-1:0] din,
   output logic [W-1:0] q,
   output logic         rco
);
   import cnt_pkg::*;

   logic [W-1:0] q_r;
   logic [W-1:0] q_nxt;
   logic         inc;

   assign inc = en_p & en_t;

   cnt_next_state #(.W(W)) u_next (
      .cur     (q_r),
      .din     (din),
      .clr_req (~clr_n),
      .ld_req  (~ld_n),
      .inc_req (inc),
      .nxt     (q_nxt)
   );

   generate
      if (CLR_MODE == CLR_SYNC) begin : g_sync_clr
         always_ff @(posedge clk) begin
            q_r <= q_nxt;
         end
      end else begin : g_async_clr
         always_ff @(posedge clk or negedge clr_n) begin
            if (!clr_n) q_r <= '0;
            else        q_r <= q_nxt;
         end
      end
   endgenerate

   cnt_carry #(.W(W)) u_carry (
      .cur  (q_r),
      .en_t (en_t),
      .rco  (rco)
   );

   assign q = q_r;

endmodule

// File: rtl/presettable_counter_chain.sv
// Chain of N_STAGES counting stages; each carry drives the next T enable.
module presettable_counter_chain #(
   parameter int unsigned        DIGIT_W  = 4,
   parameter int unsigned        N_STAGES = 1,
   parameter cnt_pkg::clr_mode_e CLR_MODE = cnt_pkg::CLR_ASYNC
) (
   input  logic                          clk,
   input  logic                          clr_n,
   input  logic                          load_n,
   input  logic                          cen_p,
   input  logic                          cen_t,
   input  logic [DIGIT_W*N_STAGES-1:0]   pdata,
   output logic [DIGIT_W*N_STAGES-1:0]   count,
   output logic                          carry_out
);
   localparam int unsigned TOT_W = DIGIT_W * N_STAGES;

   generate
      if (DIGIT_W < 1) begin : g_bad_width
         $error("presettable_counter_chain: DIGIT_W must be at least 1");
      end
      if (N_STAGES < 1) begin : g_bad_stages
         $error("presettable_counter_chain: N_STAGES must be at least 1");
      end
      if (TOT_W > 1024) begin : g_bad_total
         $error("presettable_counter_chain: total width above 1024 bits");
      end
   endgenerate

   logic [N_STAGES:0] t_chain;

   assign t_chain[0] = cen_t;

   generate
      for (genvar s = 0; s < N_STAGES; s++) begin : g_stage
         cnt_stage #(.W(DIGIT_W), .CLR_MODE(CLR_MODE)) u_stage (
            .clk   (clk),
            .clr_n (clr_n),
            .ld_n  (load_n),
            .en_p  (cen_p),
            .en_t  (t_chain[s]),
            .din   (pdata[s*DIGIT_W +: DIGIT_W]),
            .q     (count[s*DIGIT_W +: DIGIT_W]),
            .rco   (t_chain[s+1])
         );
      end
   endgenerate

   assign carry_out = t_chain[N_STAGES];

endmodule

// File: rtl/presettable_counter_chain_chk.sv
// Property checker attached to every presettable_counter_chain instance.
module presettable_counter_chain_chk #(
   parameter int unsigned        DIGIT_W  = 4,
   parameter int unsigned        N_STAGES = 1,
   parameter cnt_pkg::clr_mode_e CLR_MODE = cnt_pkg::CLR_ASYNC
) (
   input logic                        clk,
   input logic                        clr_n,
   input logic                        load_n,
   input logic                        cen_p,
   input logic                        cen_t,
   input logic [DIGIT_W*N_STAGES-1:0] pdata,
   input logic [DIGIT_W*N_STAGES-1:0] count,
   input logic                        carry_out
);
   import cnt_pkg::*;
   localparam int unsigned TOT_W = DIGIT_W * N_STAGES;

   // R2: load captures the parallel data whatever the enables
   p_load_capture_r2: assert property (@(posedge clk) disable iff (!clr_n)
      !load_n |=> count == $past(pdata));

   // R5, R8: both enables high advance the whole chain by one
   p_count_step_r5: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && cen_p && cen_t) |=> count == TOT_W'($past(count) + 1'b1));

   // R6: any enable low holds the count
   p_hold_r6: assert property (@(posedge clk) disable iff (!clr_n)
      (load_n && !(cen_p && cen_t)) |=> $stable(count));

   // R7: carry only with T high at the terminal count of the chain
   p_carry_decode_r7: assert property (@(posedge clk) disable iff (!clr_n)
      carry_out == (cen_t && (&count)));

   generate
      if (CLR_MODE == CLR_SYNC) begin : g_sync_chk
         // R4: clear seen at an edge gives zero after that edge
         p_sync_clear_r4: assert property (@(posedge clk)
            !clr_n |=> count == '0);
      end else begin : g_async_chk
         // R3: while clear is low the count already reads zero at the edge
         p_async_clear_r3: assert property (@(posedge clk)
            !clr_n |-> count == '0);
      end
   endgenerate

endmodule

bind presettable_counter_chain presettable_counter_chain_chk #(
   .DIGIT_W  (DIGIT_W),
   .N_STAGES (N_STAGES),
   .CLR_MODE (CLR_MODE)
) u_chk (
   .clk       (clk),
   .clr_n     (clr_n),
   .load_n    (load_n),
   .cen_p     (cen_p),
   .cen_t     (cen_t),
   .pdata     (pdata),
   .count     (count),
   .carry_out (carry_out)
);

// File: tb/presettable_counter_chain_tb_top.sv
`timescale 1ns/1ps
module presettable_counter_chain_tb_top;
   import cnt_pkg::*;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   int n_tests = 0;
   int n_fail  = 0;
   logic done = 1'b0;

   // single-stage stimulus, shared by the async and sync copies
   logic       clr_n = 1'b0, ld_n = 1'b1, ep = 1'b0, et = 1'b0;
   logic [3:0] din = '0;
   logic       mod_mode = 1'b0;
   logic [3:0] aq, sq;
   logic       ac, sc;
   logic       s_clr_n;

   assign s_clr_n = mod_mode ? (sq != 4'd9) : clr_n;

   presettable_counter_chain #(.DIGIT_W(4), .N_STAGES(1), .CLR_MODE(CLR_ASYNC)) dut_i (
      .clk(clk), .clr_n(clr_n), .load_n(ld_n), .cen_p(ep), .cen_t(et),
      .pdata(din), .count(aq), .carry_out(ac));

   presettable_counter_chain #(.DIGIT_W(4), .N_STAGES(1), .CLR_MODE(CLR_SYNC)) sdut_i (
      .clk(clk), .clr_n(s_clr_n), .load_n(ld_n), .cen_p(ep), .cen_t(et),
      .pdata(din), .count(sq), .carry_out(sc));

   // three-stage chain
   logic        c_clr_n = 1'b0, c_ld_n = 1'b1, c_p = 1'b1, c_t = 1'b0;
   logic [11:0] c_din = '0;
   logic [11:0] c_q;
   logic        c_c;

   presettable_counter_chain #(.DIGIT_W(4), .N_STAGES(3), .CLR_MODE(CLR_SYNC)) chain_i (
      .clk(clk), .clr_n(c_clr_n), .load_n(c_ld_n), .cen_p(c_p), .cen_t(c_t),
      .pdata(c_din), .count(c_q), .carry_out(c_c));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // {clr_n,ld_n,P,T} din expected_q expected_carry (one hex digit each)
   localparam logic [15:0] VEC [15] = '{
      16'h4000, // clear
      16'h8CC0, // preset twelve, enables low
      16'hF0D0, 16'hF0E0, 16'hF0F1, 16'hF000, 16'hF010, 16'hF020,
      16'hD020, // P low: hold
      16'hE020, // T low: hold
      16'h8990, // load with both enables low
      16'hB550, // load overrides counting
      16'h3700, // clear overrides load
      16'h8FF0, // fifteen with T low: no carry
      16'hD0F1  // T high, P low: carry, hold
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [11:0] model;
      logic [3:0]  m;
      // reset state after a clear edge
      @(negedge clk);
      @(posedge clk); #2;
      chk("R3 reset async", aq, 0);
      chk("R4 reset sync", sq, 0);

      // vector table, R2 R5 R6 R7 R3 R4
      for (int i = 0; i < 15; i++) begin
         @(negedge clk);
         {clr_n, ld_n, ep, et} = VEC[i][15:12];
         din = VEC[i][11:8];
         @(posedge clk); #2;
         chk($sformatf("R2/R5/R6 vec%0d async q", i), aq, VEC[i][7:4]);
         chk($sformatf("R2/R5/R6 vec%0d sync q", i), sq, VEC[i][7:4]);
         chk($sformatf("R7 vec%0d async carry", i), ac, VEC[i][0]);
         chk($sformatf("R7 vec%0d sync carry", i), sc, VEC[i][0]);
      end

      // R7: carry follows T with no clock edge (count is 15)
      @(negedge clk); et = 1'b0; #1;
      chk("R7 carry drops with T", ac, 0);
      et = 1'b1; #1;
      chk("R7 carry rises with T", ac, 1);

      // R1: a load pulse between edges has no effect
      @(negedge clk); clr_n = 1'b1; ld_n = 1'b0; ep = 1'b0; et = 1'b0; din = 4'd6;
      @(posedge clk); #2;
      @(negedge clk); ld_n = 1'b0; din = 4'd3; #1;
      chk("R1 no change before edge", aq, 6);
      ld_n = 1'b1; ep = 1'b1; #1; ep = 1'b0;
      @(posedge clk); #2;
      chk("R1 pulse ignored async", aq, 6);
      chk("R1 pulse ignored sync", sq, 6);

      // R3 vs R4: clear mid-cycle
      @(negedge clk); clr_n = 1'b0; #1;
      chk("R3 async clear immediate", aq, 0);
      chk("R4 sync clear waits for edge", sq, 6);
      @(posedge clk); #2;
      chk("R4 sync clear after edge", sq, 0);
      chk("R3 async stays zero", aq, 0);

      // R9: decode of nine drives synchronous clear
      @(negedge clk); clr_n = 1'b1; ld_n = 1'b1; ep = 1'b1; et = 1'b1; mod_mode = 1'b1;
      m = 4'd0;
      for (int k = 0; k < 25; k++) begin
         @(posedge clk); #2;
         m = (m == 4'd9) ? 4'd0 : m + 4'd1;
         chk($sformatf("R9 modulo step %0d", k), sq, m);
      end
      @(negedge clk); mod_mode = 1'b0;

      // R8: chain near boundaries
      @(negedge clk); c_clr_n = 1'b1; c_ld_n = 1'b0; c_din = 12'hFFD;
      @(posedge clk); #2;
      chk("R8 chain load", c_q, 12'hFFD);
      model = 12'hFFD;
      @(negedge clk); c_ld_n = 1'b1; c_t = 1'b1; c_p = 1'b1;
      for (int k = 0; k < 6; k++) begin
         @(posedge clk); #2;
         model = model + 12'd1;
         chk($sformatf("R8 chain wrap q %0d", k), c_q, model);
         chk($sformatf("R8 chain wrap carry %0d", k), c_c, model == 12'hFFF);
      end
      @(negedge clk); c_ld_n = 1'b0; c_din = 12'h0EE;
      @(posedge clk); #2;
      model = 12'h0EE;
      @(negedge clk); c_ld_n = 1'b1;
      for (int k = 0; k < 40; k++) begin
         @(posedge clk); #2;
         model = model + 12'd1;
         chk($sformatf("R8 chain cross q %0d", k), c_q, model);
      end
      @(negedge clk); c_t = 1'b0;
      @(posedge clk); #2;
      chk("R6 chain hold T low", c_q, model);
      @(negedge clk); c_t = 1'b1; c_p = 1'b0;
      @(posedge clk); #2;
      chk("R6 chain hold P low", c_q, model);
      @(negedge clk); c_clr_n = 1'b0; c_p = 1'b1;
      @(posedge clk); #2;
      chk("R8 chain clear", c_q, 0);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule